// File: doc/BRIEF.md
# ADC Result Overwrite-Protection Controller

This block owns the single result register of an A/D converter and guards it against loss. Each finished conversion arrives as a one-cycle strobe with its data word. The block normally copies that word into the result register and raises a result flag. If the previous result has not yet been serviced and protection is armed, the block does not overwrite the register. It parks the new word in a side buffer and asserts a hold that freezes the conversion sequencer. The block commits the parked word and drops the hold as soon as the old result is serviced.

A result is serviced in one of two ways. In CPU service mode, software clears the result flag and the block raises an interrupt request while the flag is up. In transfer service mode, a memory-transfer engine is asked to move the result, and its completion pulse counts as the service. A pause entered in transfer mode raises a sticky pause flag, which only software can clear. The block also produces the start pulse for the sequencer. The pulse follows a software start and, in continuous mode, follows each commit.

Top module: `adc_result_guard`

## Requirements
- R1: After reset the result register reads 0 and the result flag, pause flag, hold, interrupt request, transfer request and start pulse are all 0.
- R2: A conversion strobe that is not protected writes its data to the result register and sets the result flag; both are visible after the next clock edge.
- R3: With `svc_xfer`=0, `irq` is 1 exactly when the result flag and `prot_en` are both 1, and `xfer_req` is 0. With `svc_xfer`=1, `xfer_req` takes that value and `irq` is 0.
- R4: If a strobe arrives while `prot_en`=1 and the result flag is 1 and not being serviced in that cycle, the result register stays unchanged and `seq_hold` reads 1 after the edge.
- R5: While held, a flag write with `csr_wdata[0]`=0 commits the buffered word to the result register, leaves the result flag at 1 and releases `seq_hold`, all at the next edge.
- R6: With `svc_xfer`=1, `xfer_done` services the result. It clears the result flag when nothing is held. When a word is held, it commits that word and sets the flag again, as in R5.
- R7: Entering a pause sets `pause_flag` only when `svc_xfer`=1. Hardware never clears it. Only a flag write with `csr_wdata[1]`=0 clears it.
- R8: A flag write carrying 1 in a flag's bit (bit 0 is the result flag, bit 1 is the pause flag) leaves that flag and the hold unchanged.
- R9: With `prot_en`=0, a strobe overwrites the result register at once, even when the result flag is 1, and never raises `seq_hold`.
- R10: `sw_start` gives a one-cycle `seq_start` after the next edge. With `cont_mode`=1 every commit also gives `seq_start` in the cycle the new result first appears. With `cont_mode`=0 a commit gives no start.
- R11: If a strobe and a service event (flag clear or `xfer_done`) fall in the same cycle, the strobe commits directly and `seq_hold` stays 0.
- R12: A strobe that arrives while `seq_hold` is 1 is dropped. The word committed at release is the one captured at the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | Conversion finished strobe |
| conv_data | input | DATA_W | Finished conversion word |
| prot_en | input | 1 | Interrupt/protection enable |
| svc_xfer | input | 1 | 1: transfer engine services results; 0: CPU |
| cont_mode | input | 1 | 1: continuous conversion; 0: single |
| sw_start | input | 1 | Software start request |
| csr_wr | input | 1 | Flag write strobe |
| csr_wdata | input | 2 | Flag write data: bit 0 result flag, bit 1 pause flag; 0 clears |
| xfer_done | input | 1 | Transfer engine finished moving the result |
| result | output | DATA_W | Result register |
| int_flag | output | 1 | Result flag |
| pause_flag | output | 1 | Sticky pause flag |
| seq_hold | output | 1 | Freeze the sequencer |
| seq_start | output | 1 | Start a conversion |
| irq | output | 1 | Interrupt request |
| xfer_req | output | 1 | Request to the transfer engine |

## Verification
A finishing conversion and the servicing of the previous result can fall in the same cycle. The bench provokes this in two ways. It drives a strobe in the same cycle as a flag-clear write, and it drives a strobe in the cycle just after a pause has begun, while the hold is up. In the first case the expected outcome is a direct commit with no hold. In the second the strobe must be dropped, and the word later committed must be the parked one. The bench also presses `xfer_done` against a held word and against an idle flag, and checks that the two cases give different flag results.

// File: rtl/adc_guard_pkg.sv
package adc_guard_pkg;
    localparam int FLAG_W         = 2;
    localparam int FLAG_RES_BIT   = 0;
    localparam int FLAG_PAUSE_BIT = 1;

    typedef enum logic {
        SVC_CPU  = 1'b0,
        SVC_XFER = 1'b1
    } svc_mode_e;
endpackage

// File: rtl/adc_guard_csr.sv
module adc_guard_csr
    import adc_guard_pkg::*;
(
    input  logic              csr_wr,
    input  logic [FLAG_W-1:0] csr_wdata,
    output logic              clr_res,
    output logic              clr_pause
);
    // Only a written 0 acts; a written 1 is discarded.
    always_comb begin
        clr_res   = csr_wr && !csr_wdata[FLAG_RES_BIT];
        clr_pause = csr_wr && !csr_wdata[FLAG_PAUSE_BIT];
    end
endmodule

// File: rtl/adc_guard_steer.sv
module adc_guard_steer
    import adc_guard_pkg::*;
(
    input  logic      flag_q,
    input  logic      prot_en,
    input  svc_mode_e mode,
    output logic      irq,
    output logic      xfer_req
);
    logic want;

    always_comb begin
        want     = flag_q && prot_en;
        irq      = want && (mode == SVC_CPU);
        xfer_req = want && (mode == SVC_XFER);
    end
endmodule

// File: rtl/adc_guard_core.sv
module adc_guard_core
    import adc_guard_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              prot_en,
    input  svc_mode_e         mode,
    input  logic              cont_mode,
    input  logic              sw_start,
    input  logic              clr_res,
    input  logic              clr_pause,
    input  logic              xfer_done,
    output logic [DATA_W-1:0] result,
    output logic              flag_q,
    output logic              pause_q,
    output logic              hold_q,
    output logic              start_q
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [DATA_W-1:0] park;
        logic              flag;
        logic              pause;
        logic              pend;
        logic              start;
    } st_t;

    st_t st_d, st_q;

    logic service_evt, flag_live, accept, protect, release_now, commit_new, commit_any;

    always_comb begin
        service_evt = clr_res || (xfer_done && mode == SVC_XFER);
        flag_live   = st_q.flag && !service_evt;
        release_now = st_q.pend && service_evt;
        accept      = conv_done && !st_q.pend;
        protect     = accept && prot_en && flag_live;
        commit_new  = accept && !protect;
        commit_any  = release_now || commit_new;

        st_d       = st_q;
        st_d.start = sw_start || (commit_any && cont_mode);
        if (service_evt) st_d.flag  = 1'b0;
        if (clr_pause)   st_d.pause = 1'b0;
        if (protect) begin
            st_d.pend = 1'b1;
            st_d.park = conv_data;
            if (mode == SVC_XFER) st_d.pause = 1'b1;
        end
        if (release_now) begin
            st_d.res  = st_q.park;
            st_d.pend = 1'b0;
            st_d.flag = 1'b1;
        end else if (commit_new) begin
            st_d.res  = conv_data;
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result  = st_q.res;
    assign flag_q  = st_q.flag;
    assign pause_q = st_q.pause;
    assign hold_q  = st_q.pend;
    assign start_q = st_q.start;
endmodule

// File: rtl/adc_result_guard.sv
module adc_result_guard
    import adc_guard_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              prot_en,
    input  logic              svc_xfer,
    input  logic              cont_mode,
    input  logic              sw_start,
    input  logic              csr_wr,
    input  logic [1:0]        csr_wdata,
    input  logic              xfer_done,
    output logic [DATA_W-1:0] result,
    output logic              int_flag,
    output logic              pause_flag,
    output logic              seq_hold,
    output logic              seq_start,
    output logic              irq,
    output logic              xfer_req
);
    logic      clr_res, clr_pause;
    svc_mode_e mode;

    assign mode = svc_mode_e'(svc_xfer);

    adc_guard_csr u_csr (
        .csr_wr    (csr_wr),
        .csr_wdata (csr_wdata),
        .clr_res   (clr_res),
        .clr_pause (clr_pause)
    );

    adc_guard_core #(.DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .prot_en   (prot_en),
        .mode      (mode),
        .cont_mode (cont_mode),
        .sw_start  (sw_start),
        .clr_res   (clr_res),
        .clr_pause (clr_pause),
        .xfer_done (xfer_done),
        .result    (result),
        .flag_q    (int_flag),
        .pause_q   (pause_flag),
        .hold_q    (seq_hold),
        .start_q   (seq_start)
    );

    adc_guard_steer u_steer (
        .flag_q   (int_flag),
        .prot_en  (prot_en),
        .mode     (mode),
        .irq      (irq),
        .xfer_req (xfer_req)
    );
endmodule

// File: rtl/adc_result_guard_chk.sv
module adc_result_guard_chk #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_done,
    input logic [DATA_W-1:0] conv_data,
    input logic              prot_en,
    input logic              svc_xfer,
    input logic              cont_mode,
    input logic              sw_start,
    input logic              csr_wr,
    input logic [1:0]        csr_wdata,
    input logic              xfer_done,
    input logic [DATA_W-1:0] result,
    input logic              int_flag,
    input logic              pause_flag,
    input logic              seq_hold,
    input logic              seq_start,
    input logic              irq,
    input logic              xfer_req
);
    logic svc_now;
    assign svc_now = (csr_wr && !csr_wdata[0]) || (xfer_done && svc_xfer);

    // R3
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (int_flag && prot_en && !svc_xfer && !xfer_req));

    // R4
    protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !seq_hold && prot_en && int_flag && !svc_now)
        |=> (seq_hold && $stable(result)));

    // R12
    held_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_hold && !svc_now) |=> (seq_hold && $stable(result)));

    // R5
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_hold && svc_now) |=> (!seq_hold && int_flag));

    // R7
    pause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_flag && !(csr_wr && !csr_wdata[1])) |=> pause_flag);

    // R9
    unprotected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_en && conv_done && !seq_hold)
        |=> (!seq_hold && int_flag && result == $past(conv_data)));

    // R10
    single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cont_mode && !sw_start) |=> !seq_start);
endmodule

bind adc_result_guard adc_result_guard_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
    .prot_en(prot_en), .svc_xfer(svc_xfer), .cont_mode(cont_mode),
    .sw_start(sw_start), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .xfer_done(xfer_done), .result(result), .int_flag(int_flag),
    .pause_flag(pause_flag), .seq_hold(seq_hold), .seq_start(seq_start),
    .irq(irq), .xfer_req(xfer_req)
);

// File: tb/adc_result_guard_bench.sv
module adc_result_guard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 10;
    localparam int NVEC       = 14;

    typedef struct packed {
        logic          cd;
        logic [DW-1:0] data;
        logic          en;
        logic          xf;
        logic          ct;
        logic          wr;
        logic [1:0]    wd;
        logic          xd;
        logic          st;
        logic [DW-1:0] e_res;
        logic          e_int;
        logic          e_pau;
        logic          e_hold;
        logic          e_irq;
        logic          e_xreq;
        logic          e_start;
        logic [3:0]    req;
    } vec_t;

    // cd data en xf ct wr wd xd st | res int pau hold irq xreq start | req
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 10'h000, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b1, 10'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd10}, // R10 start
        '{1'b1, 10'h011, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 10'h011, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 R3
        '{1'b1, 10'h022, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 10'h011, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd4},  // R4, R7 no pause in CPU mode
        '{1'b0, 10'h000, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 10'h011, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 write ones
        '{1'b1, 10'h033, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 10'h011, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd12}, // R12 dropped
        '{1'b0, 10'h000, 1'b1, 1'b0, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0, 10'h022, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 release
        '{1'b1, 10'h044, 1'b1, 1'b0, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0, 10'h044, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd11}, // R11 same cycle
        '{1'b1, 10'h055, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 10'h055, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 R3
        '{1'b0, 10'h000, 1'b1, 1'b1, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0, 10'h055, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 clear
        '{1'b1, 10'h066, 1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 10'h066, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd10}, // R10 R3 xfer
        '{1'b1, 10'h077, 1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 10'h066, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd7},  // R7 pause set
        '{1'b0, 10'h000, 1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 1'b1, 1'b0, 10'h077, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 release
        '{1'b0, 10'h000, 1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 1'b1, 1'b0, 10'h077, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 clear, R7 sticky
        '{1'b0, 10'h000, 1'b1, 1'b1, 1'b0, 1'b1, 2'b01, 1'b0, 1'b0, 10'h077, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7}   // R7 sw clear
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv_done = 1'b0;
    logic [DW-1:0] conv_data = '0;
    logic          prot_en = 1'b0, svc_xfer = 1'b0, cont_mode = 1'b0, sw_start = 1'b0;
    logic          csr_wr = 1'b0, xfer_done = 1'b0;
    logic [1:0]    csr_wdata = 2'b11;
    logic [DW-1:0] result;
    logic          int_flag, pause_flag, seq_hold, seq_start, irq, xfer_req;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_result_guard #(.DATA_W(DW)) u_adc_result_guard (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
        .prot_en(prot_en), .svc_xfer(svc_xfer), .cont_mode(cont_mode),
        .sw_start(sw_start), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .xfer_done(xfer_done), .result(result), .int_flag(int_flag),
        .pause_flag(pause_flag), .seq_hold(seq_hold), .seq_start(seq_start),
        .irq(irq), .xfer_req(xfer_req)
    );

    function automatic logic [DW+5:0] observed();
        return {result, int_flag, pause_flag, seq_hold, irq, xfer_req, seq_start};
    endfunction

    task automatic check(input string tag, input logic [DW+5:0] exp);
        n_cmp++;
        if (observed() !== exp) begin
            n_bad++;
            $display("FAIL %s: got res=%h f=%b p=%b h=%b i=%b x=%b s=%b expected res=%h f=%b p=%b h=%b i=%b x=%b s=%b",
                     tag, observed()[DW+5:6], observed()[5], observed()[4], observed()[3],
                     observed()[2], observed()[1], observed()[0],
                     exp[DW+5:6], exp[5], exp[4], exp[3], exp[2], exp[1], exp[0]);
        end
    endtask

    task automatic idle_inputs();
        conv_done = 1'b0; sw_start = 1'b0; csr_wr = 1'b0; xfer_done = 1'b0;
        csr_wdata = 2'b11;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", '0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", '0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            conv_done = VEC[i].cd; conv_data = VEC[i].data; prot_en = VEC[i].en;
            svc_xfer = VEC[i].xf; cont_mode = VEC[i].ct; csr_wr = VEC[i].wr;
            csr_wdata = VEC[i].wd; xfer_done = VEC[i].xd; sw_start = VEC[i].st;
            @(posedge clk);
            #1;
            check($sformatf("vector %0d (R%0d)", i, VEC[i].req),
                  {VEC[i].e_res, VEC[i].e_int, VEC[i].e_pau, VEC[i].e_hold,
                   VEC[i].e_irq, VEC[i].e_xreq, VEC[i].e_start});
        end

        // R12: strobe in the cycle right after a pause begins, then release
        @(negedge clk);
        idle_inputs(); prot_en = 1'b1; svc_xfer = 1'b0; cont_mode = 1'b0;
        conv_done = 1'b1; conv_data = 10'h101;
        @(negedge clk);
        conv_data = 10'h202;                  // flag now 1 -> pause
        @(negedge clk);
        conv_data = 10'h303;                  // held -> dropped
        @(negedge clk);
        idle_inputs(); csr_wr = 1'b1; csr_wdata = 2'b10;
        @(negedge clk);
        idle_inputs();
        check("R12 parked word committed", {10'h202, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0});

        // R1: reset mid-run returns everything to zero
        rst_n = 1'b0;
        #1;
        check("R1 mid-run reset", '0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R1 stays idle", '0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired: got running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule